// File: doc/BRIEF.md
# Byte-Programmable Code Array with Stepped Address Counter

This block models a small on-chip code memory while it is being programmed. Software cannot address it directly. A counter picks the byte. A rising edge on `cnt_clr_i` sends the counter back to zero, and each rising edge on `cnt_step_i` moves it forward by one. A rising edge on `prog_i` writes `wdata_i` into the selected byte, but only when that byte is still blank (0xFF). A rising edge on `erase_i` returns the whole array to 0xFF over a fixed busy window.

The byte at the current counter address is always present on `rdata_o`, so a programmer can verify each byte right after writing it. A programmer can also step through the array to check a whole image. If a write is aimed at a byte that already holds data, the byte is left as it is and the sticky flag `err_o` is raised. The programming sequence is: clear the counter, then for each byte write it, check it and step to the next. An erase comes before any rewrite.

All four control inputs are sampled on `clk_i`, and only their rising edges act. The asynchronous reset `rst_ni` puts the array into its erased state.

Top module: `flash_prog_array`

## Requirements
- R1: While `rst_ni` is low and just after it is released, every byte reads 0xFF, the counter is 0, and `busy_o` and `err_o` are 0.
- R2: A rising edge on `cnt_clr_i` sets the counter to 0 at that clock edge. This takes priority over a step edge in the same cycle.
- R3: Each rising edge on `cnt_step_i` adds exactly one to the counter. Holding the input high for several cycles counts once.
- R4: The counter is log2(DEPTH) bits wide (11 bits by default) and wraps from DEPTH-1 (0x7FF) to 0.
- R5: A `prog_i` rising edge while idle, aimed at a byte that reads 0xFF, stores `wdata_i` at the current counter address. No other byte changes.
- R6: A `prog_i` rising edge aimed at a byte that does not read 0xFF leaves the byte unchanged and sets `err_o`. `err_o` stays set after that.
- R7: `err_o` is cleared by a rising edge on `cnt_clr_i` and by the start of an erase.
- R8: An `erase_i` rising edge while idle raises `busy_o` for exactly DEPTH cycles. After that, every byte reads 0xFF.
- R9: While `busy_o` is high, `prog_i` and `erase_i` edges are ignored. They write nothing, do not change `err_o`, and do not lengthen the busy window.
- R10: `rdata_o` always shows the byte at the current counter address. It follows a counter change or a write at the same clock edge.
- R11: If `prog_i` and `erase_i` rise in the same idle cycle, the erase starts and the program request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset; array returns to erased state |
| cnt_clr_i | input | 1 | Rising edge clears the address counter and the error flag |
| cnt_step_i | input | 1 | Rising edge advances the address counter |
| prog_i | input | 1 | Rising edge requests a one-byte write |
| erase_i | input | 1 | Rising edge requests a whole-array erase |
| wdata_i | input | 8 | Byte to program |
| rdata_o | output | 8 | Byte at the current counter address |
| busy_o | output | 1 | High while an erase is sweeping the array |
| err_o | output | 1 | Sticky flag: a write hit a non-blank byte |

## Verification
The assertions assume that all four control inputs are synchronous to `clk_i`. They also assume that an edge counts as one request only if the input was low in the previous sampled cycle. The assertions check only behaviour that follows from those edges after reset is released. The stimulus changes every input on the falling clock edge and holds each strobe high for at least one full rising edge. Each strobe is then dropped, so every edge the bench intends is seen exactly once. One test deliberately holds the step input high across several edges to confirm that it counts once.

// File: rtl/flash_pkg.sv
package flash_pkg;
  localparam int unsigned DATA_W = 8;
  localparam logic [DATA_W-1:0] BLANK = '1;

  typedef enum logic [1:0] {
    EV_CLR  = 2'd0,
    EV_STEP = 2'd1,
    EV_PROG = 2'd2,
    EV_ERAS = 2'd3
  } ev_e;
  localparam int unsigned N_EV = 4;
endpackage

// File: rtl/flash_edge_det.sv
module flash_edge_det #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_det
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[g] <= 1'b0;
      else         prev_q[g] <= sig_i[g];
    end
    assign rise_o[g] = sig_i[g] & ~prev_q[g];
  end
endmodule

// File: rtl/flash_addr_cnt.sv
module flash_addr_cnt #(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (step_i && cnt_q == LAST) cnt_q <= '0;
    else if (step_i)                cnt_q <= cnt_q + 1'b1;
  end

  assign addr_o = cnt_q;

  // R2
  clr_to_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (addr_o == '0));

  // R3
  step_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !step_i) |=> $stable(addr_o));

  // R4
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && step_i && addr_o == LAST) |=> (addr_o == '0));
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          busy_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          busy_q;
  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        ptr_q  <= '0;
      end
    end else begin
      ptr_q <= ptr_q + 1'b1;
      if (ptr_q == LAST) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign we_o   = busy_q;
  assign addr_o = ptr_q;

  // R8
  busy_from_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  // R8
  sweep_complete_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ($past(addr_o) == LAST));

  // R9
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && addr_o != LAST) |=> (busy_o && addr_o == $past(addr_o) + 1'b1));
endmodule

// File: rtl/flash_byte_array.sv
module flash_byte_array
  import flash_pkg::*;
#(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ers_we_i,
  input  logic [AW-1:0]     ers_addr_i,
  input  logic              pgm_we_i,
  input  logic [AW-1:0]     pgm_addr_i,
  input  logic [DATA_W-1:0] pgm_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= BLANK;
    end else if (ers_we_i) begin
      mem_q[ers_addr_i] <= BLANK;
    end else if (pgm_we_i) begin
      mem_q[pgm_addr_i] <= pgm_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

  // R9
  port_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ers_we_i && pgm_we_i));
endmodule

// File: rtl/flash_prog_array.sv
module flash_prog_array
  import flash_pkg::*;
#(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_clr_i,
  input  logic              cnt_step_i,
  input  logic              prog_i,
  input  logic              erase_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              err_o
);
  logic [N_EV-1:0] raw, rise;
  logic [AW-1:0]   cur_addr, ers_addr;
  logic            ers_we, busy;
  logic            erase_go, prog_go, cur_blank, prog_we;
  logic            err_q;
  logic [DATA_W-1:0] cur_byte;

  assign raw[EV_CLR]  = cnt_clr_i;
  assign raw[EV_STEP] = cnt_step_i;
  assign raw[EV_PROG] = prog_i;
  assign raw[EV_ERAS] = erase_i;

  flash_edge_det #(.N(N_EV)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (raw),
    .rise_o (rise)
  );

  flash_addr_cnt #(.DEPTH(DEPTH)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (rise[EV_CLR]),
    .step_i (rise[EV_STEP]),
    .addr_o (cur_addr)
  );

  assign erase_go = rise[EV_ERAS] & ~busy;
  // erase wins over a simultaneous program request
  assign prog_go  = rise[EV_PROG] & ~busy & ~rise[EV_ERAS];

  flash_erase_seq #(.DEPTH(DEPTH)) u_ers (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (erase_go),
    .busy_o  (busy),
    .we_o    (ers_we),
    .addr_o  (ers_addr)
  );

  assign cur_blank = (cur_byte == BLANK);
  assign prog_we   = prog_go & cur_blank;

  flash_byte_array #(.DEPTH(DEPTH)) u_mem (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ers_we_i   (ers_we),
    .ers_addr_i (ers_addr),
    .pgm_we_i   (prog_we),
    .pgm_addr_i (cur_addr),
    .pgm_data_i (wdata_i),
    .rd_addr_i  (cur_addr),
    .rd_data_o  (cur_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       err_q <= 1'b0;
    else if (rise[EV_CLR] || erase_go) err_q <= 1'b0;
    else if (prog_go && !cur_blank)    err_q <= 1'b1;
  end

  assign rdata_o = cur_byte;
  assign busy_o  = busy;
  assign err_o   = err_q;

  // R6
  nonblank_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_go && !cur_blank && !busy && !rise[EV_CLR] && !rise[EV_STEP])
      |=> (rdata_o == $past(rdata_o)));

  // R6
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !rise[EV_CLR] && !erase_go) |=> err_o);

  // R7
  err_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise[EV_CLR] |=> !err_o);

  // R9
  busy_err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !rise[EV_CLR]) |=> (err_o == $past(err_o)));

  // R5
  blank_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_we && !rise[EV_CLR] && !rise[EV_STEP]) |=> (rdata_o == $past(wdata_i)));
endmodule

// File: tb/tb_flash_prog_array.sv
module tb_flash_prog_array;
  localparam int CLK_P = 10;
  localparam int DEPTH = 2048;

  // op: 0 step, 1 program, 2 counter clear
  localparam int NV = 9;
  localparam logic [18:0] VEC [NV] = '{
    {2'd1, 8'h3C, 8'h3C, 1'b0},  // R5 blank byte at 0
    {2'd0, 8'h00, 8'hFF, 1'b0},  // R3 R10 addr 1
    {2'd1, 8'hA5, 8'hA5, 1'b0},  // R5
    {2'd1, 8'h00, 8'hA5, 1'b1},  // R6 non-blank
    {2'd0, 8'h00, 8'hFF, 1'b1},  // R6 sticky, addr 2
    {2'd1, 8'hFF, 8'hFF, 1'b1},  // R5 write 0xFF stays blank
    {2'd1, 8'h81, 8'h81, 1'b1},  // R5
    {2'd2, 8'h00, 8'h3C, 1'b0},  // R2 R7
    {2'd0, 8'h00, 8'hA5, 1'b0}   // R3
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic clr = 1'b0, step = 1'b0, prog = 1'b0, ers = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic busy, err;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  flash_prog_array #(.DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_clr_i(clr), .cnt_step_i(step),
    .prog_i(prog), .erase_i(ers), .wdata_i(wdata),
    .rdata_o(rdata), .busy_o(busy), .err_o(err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // 0 step, 1 prog, 2 clr, 3 erase, 4 clr+step, 5 prog+erase
  task automatic do_op(input int op, input logic [7:0] d);
    @(negedge clk);
    wdata = d;
    case (op)
      0: step = 1'b1;
      1: prog = 1'b1;
      2: clr  = 1'b1;
      3: ers  = 1'b1;
      4: begin clr = 1'b1; step = 1'b1; end
      default: begin prog = 1'b1; ers = 1'b1; end
    endcase
    @(negedge clk);
    {clr, step, prog, ers} = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 rdata in reset", rdata, 8'hFF);
    chk("R1 busy in reset", busy, 0);
    chk("R1 err in reset", err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdata after reset", rdata, 8'hFF);

    for (int i = 0; i < NV; i++) begin
      do_op(int'(VEC[i][18:17]), VEC[i][16:9]);
      chk($sformatf("R5/R6/R10 vec %0d rdata", i), rdata, VEC[i][8:1]);
      chk($sformatf("R6/R7 vec %0d err", i), err, VEC[i][0]);
    end

    // R3: step held high several edges counts once
    do_op(2, 8'h00);
    @(negedge clk); step = 1'b1;
    repeat (3) @(negedge clk);
    step = 1'b0;
    chk("R3 held step addr1", rdata, 8'hA5);
    do_op(0, 8'h00);
    chk("R3 next step addr2", rdata, 8'h81);

    // R2: clear beats step in same cycle
    do_op(4, 8'h00);
    chk("R2 clear priority", rdata, 8'h3C);

    // R4: wrap
    for (int i = 0; i < DEPTH - 1; i++) do_op(0, 8'h00);
    chk("R4 last byte blank", rdata, 8'hFF);
    do_op(1, 8'h5A);
    chk("R5 last byte written", rdata, 8'h5A);
    do_op(0, 8'h00);
    chk("R4 wrap to 0", rdata, 8'h3C);

    // R8 R9 R7: erase with requests mid-sweep
    do_op(1, 8'h00);
    chk("R6 err set before erase", err, 1);
    do_op(3, 8'h00);
    chk("R7 err cleared by erase", err, 0);
    chk("R8 busy raised", busy, 1);
    n = 0;
    while (busy) begin
      n++;
      if (n == 5) begin prog = 1'b1; ers = 1'b1; wdata = 8'h11; end
      if (n == 6) begin prog = 1'b0; ers = 1'b0; end
      @(negedge clk);
    end
    chk("R8 R9 busy length", n, DEPTH);
    chk("R8 R9 addr0 erased, prog ignored", rdata, 8'hFF);
    chk("R9 err unchanged", err, 0);
    do_op(0, 8'h00);
    chk("R8 addr1 erased", rdata, 8'hFF);

    // R11: program and erase together
    do_op(1, 8'h42);
    chk("R5 addr1 programmed", rdata, 8'h42);
    do_op(5, 8'h24);
    chk("R11 erase started", busy, 1);
    while (busy) @(negedge clk);
    chk("R11 prog dropped, byte erased", rdata, 8'hFF);
    chk("R11 err clear", err, 0);

    finish_run();
  end
endmodule